// File: doc/BRIEF.md
# Timing Core Synchronization Controller

This block aligns the horizontal and vertical counters of a CCD timing generator to outside timing. In master mode a SYNC input whose active level is programmable, or a one-shot software request, holds the counters in reset for as long as SYNC is active. The counters restart from zero on the trailing edge. While SYNC is active, the block can optionally freeze a bus of clock outputs at programmed idle levels. In slave mode the SYNC path is ignored. The block instead watches the external VD and HD strobes. After a VD falling edge it resets the counters a fixed number of cycles after the next HD falling edge. An HD edge that arrives just before VD is flagged as an ordering violation.

All three external inputs pass through two-flop synchronizers before edge or level detection. Two enumerated state machines do the work.

The master machine has two states, `M_RUN` and `M_SYNC`:
- `M_RUN` to `M_SYNC` happens when the block is enabled in master mode and either SYNC is at its active level or a software pulse is pending.
- `M_SYNC` to `M_RUN` happens when neither condition holds.

The slave machine has four states, `S_WAIT_VD`, `S_WAIT_HD`, `S_COUNT` and `S_FIRE`:
- `S_WAIT_VD` goes to `S_COUNT` when the VD and HD falls land in the same cycle.
- `S_WAIT_VD` goes to `S_WAIT_HD` when VD falls alone.
- `S_WAIT_HD` goes to `S_COUNT` when HD falls.
- `S_COUNT` goes to `S_FIRE` when the latency count expires.
- `S_FIRE` returns to `S_WAIT_VD` unconditionally.
- Any state returns to `S_WAIT_VD` when the block is disabled or not in slave mode.

Top module: `tcore_sync_ctrl`

## Requirements
- R1: While rst_n is low, h_cnt, v_cnt, cnt_rst, out_hold and order_err are all 0.
- R2: With cnt_rst low, h_cnt steps by one each cycle and wraps from line_len-1 to 0. v_cnt increments on each wrap.
- R3: In master mode with cfg_enable=1 and cfg_sync_pol=0, SYNC is active low. cnt_rst rises 3 cycles after sync_in goes low and falls 3 cycles after sync_in returns high. h_cnt and v_cnt read 0 in the first cycle with cnt_rst low, and h_cnt reads 1 in the cycle after that.
- R4: With cfg_sync_pol=1, SYNC is active high, with the same 3-cycle latencies.
- R5: A one-cycle sw_sync_wr pulse in master mode raises cnt_rst for exactly one cycle, 2 cycles after the pulse. The counters then restart from 0.
- R6: With cfg_enable=0, neither sync_in nor sw_sync_wr raises cnt_rst.
- R7: With cfg_suspend=1, out_hold equals cnt_rst in master mode and clk_out equals idle_lvl while it is high. With cfg_suspend=0, out_hold stays 0 and clk_out follows clk_src throughout SYNC.
- R8: In slave mode (cfg_master=0), when HD falls in the same cycle as VD or later, cnt_rst pulses for one cycle exactly 39 cycles after hd_in falls.
- R9: In slave mode, if hd_in falls 1 to 5 cycles before vd_in falls, order_err pulses for one cycle 3 cycles after the VD fall, and no reset follows until a later HD fall. At 6 cycles before, no error is flagged.
- R10: The path not selected by cfg_master is ignored. In master mode, VD/HD edges cause no cnt_rst. In slave mode, sync_in causes no cnt_rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Hardware SYNC strobe |
| vd_in | input | 1 | External vertical strobe (slave mode) |
| hd_in | input | 1 | External horizontal strobe (slave mode) |
| cfg_enable | input | 1 | Enables SYNC / VD-HD processing |
| cfg_master | input | 1 | 1 = master (SYNC path), 0 = slave (VD/HD path) |
| cfg_sync_pol | input | 1 | 0 = SYNC active low, 1 = active high |
| cfg_suspend | input | 1 | Freeze clock outputs during SYNC |
| sw_sync_wr | input | 1 | Write strobe of the software sync bit |
| line_len | input | HW | Horizontal counter period in cycles |
| clk_src | input | NOUT | Clock-output levels from the waveform logic |
| idle_lvl | input | NOUT | Levels held while outputs are suspended |
| h_cnt | output | HW | Horizontal counter |
| v_cnt | output | VW | Vertical counter |
| cnt_rst | output | 1 | Counter reset request |
| out_hold | output | 1 | Clock outputs suspended |
| clk_out | output | NOUT | Clock outputs after suspend mux |
| order_err | output | 1 | HD-before-VD ordering violation pulse |

## Verification
Each external pin has two synchronizer stages, then a state register. A SYNC level change therefore shows on cnt_rst 3 cycles later. A software strobe, which skips the synchronizer but sits in a one-cycle pulse flop, shows after 2 cycles. The counters read 0 one cycle after cnt_rst rises. For the slave path, the HD fall is detected after 3 cycles and the state machine then spends 36 cycles counting, so cnt_rst rises on cycle 39; an ordering error appears 3 cycles after the VD fall. The bench drives every input on the falling clock edge, advances a fixed number of rising edges, and samples on the following falling edge. It checks the cycle just before each due cycle as well, so an early or late result fails.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
    typedef enum logic [0:0] {
        M_RUN  = 1'b0,
        M_SYNC = 1'b1
    } mstate_t;

    typedef enum logic [1:0] {
        S_WAIT_VD = 2'd0,
        S_WAIT_HD = 2'd1,
        S_COUNT   = 2'd2,
        S_FIRE    = 2'd3
    } sstate_t;
endpackage

// File: rtl/tcs_sync2.sv
module tcs_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/tcs_master_fsm.sv
module tcs_master_fsm
    import tcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pol,
    input  logic suspend,
    input  logic sync_s,
    input  logic sw_req,
    output logic rst_req,
    output logic hold
);
    mstate_t state, state_nx;
    logic    sw_pulse;
    logic    active;
    logic    req;

    // software bit: one pending pulse, cleared on the following cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_pulse <= 1'b0;
        else        sw_pulse <= sw_req & en;
    end

    assign active = pol ? sync_s : ~sync_s;
    assign req    = en & (active | sw_pulse);

    always_comb begin
        state_nx = state;
        unique case (state)
            M_RUN:  if (req)  state_nx = M_SYNC;
            M_SYNC: if (!req) state_nx = M_RUN;
            default:          state_nx = M_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= M_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        rst_req = 1'b0;
        hold    = 1'b0;
        unique case (state)
            M_RUN:  ;
            M_SYNC: begin
                rst_req = 1'b1;
                hold    = suspend;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tcs_slave_fsm.sv
module tcs_slave_fsm
    import tcs_pkg::*;
#(
    parameter int LAT   = 36,
    parameter int GUARD = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic vd_s,
    input  logic hd_s,
    output logic rst_req,
    output logic order_err
);
    localparam int LW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam int AW = $clog2(GUARD + 1);
    localparam logic [LW-1:0] LAT_LAST = LW'(LAT - 1);
    localparam logic [AW-1:0] AGE_MAX  = AW'(GUARD);

    sstate_t       state, state_nx;
    logic          vd_q, hd_q;
    logic          vd_fall, hd_fall;
    logic [LW-1:0] lat_cnt;
    logic [AW-1:0] hd_age;
    logic          too_close;

    assign vd_fall   = vd_q & ~vd_s;
    assign hd_fall   = hd_q & ~hd_s;
    assign too_close = hd_age < AGE_MAX;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_q      <= 1'b0;
            hd_q      <= 1'b0;
            hd_age    <= AGE_MAX;
            order_err <= 1'b0;
        end else begin
            vd_q      <= vd_s;
            hd_q      <= hd_s;
            hd_age    <= hd_fall ? '0 : ((hd_age == AGE_MAX) ? hd_age : hd_age + 1'b1);
            order_err <= en & vd_fall & ~hd_fall & too_close;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_WAIT_VD: if (vd_fall) state_nx = hd_fall ? S_COUNT : S_WAIT_HD;
            S_WAIT_HD: if (hd_fall) state_nx = S_COUNT;
            S_COUNT:   if (lat_cnt == LAT_LAST) state_nx = S_FIRE;
            S_FIRE:    state_nx = S_WAIT_VD;
            default:   state_nx = S_WAIT_VD;
        endcase
        if (!en) state_nx = S_WAIT_VD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_WAIT_VD;
            lat_cnt <= '0;
        end else begin
            state   <= state_nx;
            lat_cnt <= (state == S_COUNT) ? lat_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        rst_req = 1'b0;
        unique case (state)
            S_WAIT_VD, S_WAIT_HD, S_COUNT: rst_req = 1'b0;
            S_FIRE:                        rst_req = 1'b1;
            default:                       rst_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcs_counters.sv
module tcs_counters #(
    parameter int HW = 12,
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [HW-1:0] line_len,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt
);
    logic [HW:0] h_inc;
    logic        wrap;

    assign h_inc = {1'b0, h_cnt} + 1'b1;
    assign wrap  = h_inc >= {1'b0, line_len};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (clr) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (wrap) begin
            h_cnt <= '0;
            v_cnt <= v_cnt + 1'b1;
        end else begin
            h_cnt <= h_inc[HW-1:0];
        end
    end
endmodule

// File: rtl/tcore_sync_ctrl.sv
module tcore_sync_ctrl #(
    parameter int HW    = 12,
    parameter int VW    = 12,
    parameter int NOUT  = 8,
    parameter int LAT   = 36,
    parameter int GUARD = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_in,
    input  logic            vd_in,
    input  logic            hd_in,
    input  logic            cfg_enable,
    input  logic            cfg_master,
    input  logic            cfg_sync_pol,
    input  logic            cfg_suspend,
    input  logic            sw_sync_wr,
    input  logic [HW-1:0]   line_len,
    input  logic [NOUT-1:0] clk_src,
    input  logic [NOUT-1:0] idle_lvl,
    output logic [HW-1:0]   h_cnt,
    output logic [VW-1:0]   v_cnt,
    output logic            cnt_rst,
    output logic            out_hold,
    output logic [NOUT-1:0] clk_out,
    output logic            order_err
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] PIN_RST = '1;

    logic [NPIN-1:0] pin_raw, pin_s;
    logic            m_rst, s_rst;

    assign pin_raw = {hd_in, vd_in, sync_in};

    for (genvar i = 0; i < NPIN; i++) begin : g_sync
        tcs_sync2 #(.RST_VAL(PIN_RST[i])) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pin_raw[i]),
            .q     (pin_s[i])
        );
    end

    tcs_master_fsm u_master (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_enable & cfg_master),
        .pol     (cfg_sync_pol),
        .suspend (cfg_suspend),
        .sync_s  (pin_s[0]),
        .sw_req  (sw_sync_wr),
        .rst_req (m_rst),
        .hold    (out_hold)
    );

    tcs_slave_fsm #(.LAT(LAT), .GUARD(GUARD)) u_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_enable & ~cfg_master),
        .vd_s      (pin_s[1]),
        .hd_s      (pin_s[2]),
        .rst_req   (s_rst),
        .order_err (order_err)
    );

    assign cnt_rst = m_rst | s_rst;

    tcs_counters #(.HW(HW), .VW(VW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_rst),
        .line_len (line_len),
        .h_cnt    (h_cnt),
        .v_cnt    (v_cnt)
    );

    for (genvar k = 0; k < NOUT; k++) begin : g_hold
        assign clk_out[k] = out_hold ? idle_lvl[k] : clk_src[k];
    end
endmodule

// File: rtl/tcs_sync_chk.sv
module tcs_sync_chk #(
    parameter int HW = 12,
    parameter int VW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_enable,
    input logic          cfg_suspend,
    input logic          cnt_rst,
    input logic          out_hold,
    input logic          order_err,
    input logic [HW-1:0] h_cnt,
    input logic [VW-1:0] v_cnt,
    input logic [HW-1:0] line_len
);
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_rst && ({1'b0, h_cnt} + 1'b1 < {1'b0, line_len}))
        |=> (h_cnt == $past(h_cnt) + 1'b1));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_rst && ({1'b0, h_cnt} + 1'b1 >= {1'b0, line_len}))
        |=> (h_cnt == '0 && v_cnt == $past(v_cnt) + 1'b1));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> (h_cnt == '0 && v_cnt == '0));

    p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !cnt_rst);

    p_hold_in_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_hold |-> (cnt_rst && cfg_suspend));

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |=> !order_err);
endmodule

bind tcore_sync_ctrl tcs_sync_chk #(.HW(HW), .VW(VW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .cfg_suspend (cfg_suspend),
    .cnt_rst     (cnt_rst),
    .out_hold    (out_hold),
    .order_err   (order_err),
    .h_cnt       (h_cnt),
    .v_cnt       (v_cnt),
    .line_len    (line_len)
);

// File: tb/tb_tcore_sync_ctrl.sv
module tb_tcore_sync_ctrl;
    localparam int HW = 12;
    localparam int VW = 12;
    localparam int NOUT = 8;
    localparam logic [NOUT-1:0] SRC  = 8'hA5;
    localparam logic [NOUT-1:0] IDLE = 8'h3C;

    // row: {sync_in, expected cnt_rst, expected h_cnt (15 = don't care)}
    localparam int NV = 10;
    localparam logic [5:0] VEC [NV] = '{
        {1'b1, 1'b0, 4'd15}, {1'b1, 1'b0, 4'd15}, {1'b0, 1'b0, 4'd15},
        {1'b0, 1'b0, 4'd15}, {1'b0, 1'b1, 4'd15}, {1'b0, 1'b1, 4'd0},
        {1'b1, 1'b1, 4'd0},  {1'b1, 1'b1, 4'd0},  {1'b1, 1'b0, 4'd0},
        {1'b1, 1'b0, 4'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b1, vd_in = 1'b1, hd_in = 1'b1;
    logic cfg_enable = 1'b1, cfg_master = 1'b1, cfg_sync_pol = 1'b0, cfg_suspend = 1'b1;
    logic sw_sync_wr = 1'b0;
    logic [HW-1:0] line_len = 12'd1000;
    logic [NOUT-1:0] clk_src = SRC, idle_lvl = IDLE;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic cnt_rst, out_hold, order_err;
    logic [NOUT-1:0] clk_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tcore_sync_ctrl #(.HW(HW), .VW(VW), .NOUT(NOUT)) dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .vd_in(vd_in), .hd_in(hd_in),
        .cfg_enable(cfg_enable), .cfg_master(cfg_master), .cfg_sync_pol(cfg_sync_pol),
        .cfg_suspend(cfg_suspend), .sw_sync_wr(sw_sync_wr), .line_len(line_len),
        .clk_src(clk_src), .idle_lvl(idle_lvl), .h_cnt(h_cnt), .v_cnt(v_cnt),
        .cnt_rst(cnt_rst), .out_hold(out_hold), .clk_out(clk_out), .order_err(order_err)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic count_rst(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (cnt_rst) hits++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int hits;
        step(3);
        chk("R1 h_cnt", int'(h_cnt), 0);
        chk("R1 v_cnt", int'(v_cnt), 0);
        chk("R1 cnt_rst", int'(cnt_rst), 0);
        chk("R1 out_hold", int'(out_hold), 0);
        chk("R1 order_err", int'(order_err), 0);
        rst_n = 1'b1;
        step(6);

        // R3 / R7 table: active-low SYNC with suspend on
        for (int i = 0; i < NV; i++) begin
            sync_in = VEC[i][5];
            step(1);
            chk("R3 cnt_rst", int'(cnt_rst), int'(VEC[i][4]));
            chk("R7 out_hold", int'(out_hold), int'(VEC[i][4]));
            chk("R7 clk_out", int'(clk_out), VEC[i][4] ? int'(IDLE) : int'(SRC));
            if (VEC[i][3:0] != 4'd15) chk("R3 h_cnt", int'(h_cnt), int'(VEC[i][3:0]));
        end

        // R5 software sync and R2 wrap at line_len=5
        line_len = 12'd5;
        sw_sync_wr = 1'b1;
        step(1);
        sw_sync_wr = 1'b0;
        chk("R5 no early rst", int'(cnt_rst), 0);
        step(1);
        chk("R5 cnt_rst", int'(cnt_rst), 1);
        step(1);
        chk("R5 single cycle", int'(cnt_rst), 0);
        chk("R5 h_cnt restart", int'(h_cnt), 0);
        for (int j = 1; j <= 6; j++) begin
            step(1);
            chk("R2 h_cnt", int'(h_cnt), j % 5);
            chk("R2 v_cnt", int'(v_cnt), j / 5);
        end
        line_len = 12'd1000;

        // R8 slave: VD and HD fall together
        cfg_master = 1'b0;
        step(4);
        vd_in = 1'b0; hd_in = 1'b0;
        step(38);
        chk("R8 early", int'(cnt_rst), 0);
        step(1);
        chk("R8 cnt_rst", int'(cnt_rst), 1);
        step(1);
        chk("R8 h_cnt zero", int'(h_cnt), 0);
        chk("R8 pulse width", int'(cnt_rst), 0);
        step(1);
        chk("R8 h_cnt one", int'(h_cnt), 1);
        vd_in = 1'b1; hd_in = 1'b1;
        step(8);

        // R8 slave: HD falls three cycles after VD
        vd_in = 1'b0;
        step(3);
        hd_in = 1'b0;
        step(38);
        chk("R8 late hd early", int'(cnt_rst), 0);
        step(1);
        chk("R8 late hd cnt_rst", int'(cnt_rst), 1);
        vd_in = 1'b1; hd_in = 1'b1;
        step(8);

        // R9 HD five cycles before VD: error
        hd_in = 1'b0;
        step(5);
        vd_in = 1'b0;
        step(2);
        chk("R9 early", int'(order_err), 0);
        step(1);
        chk("R9 order_err", int'(order_err), 1);
        step(1);
        chk("R9 pulse width", int'(order_err), 0);
        count_rst(45, hits);
        chk("R9 no reset", hits, 0);
        vd_in = 1'b1; hd_in = 1'b1;
        step(8);

        // R9 HD six cycles before VD: no error
        hd_in = 1'b0;
        step(6);
        vd_in = 1'b0;
        step(3);
        chk("R9 guard edge", int'(order_err), 0);
        vd_in = 1'b1; hd_in = 1'b1;
        step(8);

        // R10 slave ignores SYNC
        sync_in = 1'b0;
        count_rst(10, hits);
        chk("R10 slave ignores sync", hits, 0);
        sync_in = 1'b1;
        step(4);

        // R10 master ignores VD/HD
        cfg_master = 1'b1;
        step(4);
        vd_in = 1'b0; hd_in = 1'b0;
        count_rst(45, hits);
        chk("R10 master ignores vd/hd", hits, 0);
        vd_in = 1'b1; hd_in = 1'b1;
        step(4);

        // R6 disabled
        cfg_enable = 1'b0;
        sync_in = 1'b0;
        count_rst(10, hits);
        chk("R6 sync ignored", hits, 0);
        sw_sync_wr = 1'b1;
        step(1);
        sw_sync_wr = 1'b0;
        count_rst(5, hits);
        chk("R6 sw ignored", hits, 0);

        // R4 active-high SYNC
        cfg_sync_pol = 1'b1;
        step(4);
        cfg_enable = 1'b1;
        step(3);
        chk("R4 idle low", int'(cnt_rst), 0);
        sync_in = 1'b1;
        step(2);
        chk("R4 early", int'(cnt_rst), 0);
        step(1);
        chk("R4 cnt_rst", int'(cnt_rst), 1);
        sync_in = 1'b0;
        step(3);
        chk("R4 release", int'(cnt_rst), 0);

        // R7 suspend off: outputs keep running
        cfg_suspend = 1'b0;
        sync_in = 1'b1;
        step(3);
        chk("R7 rst without hold", int'(cnt_rst), 1);
        chk("R7 out_hold off", int'(out_hold), 0);
        chk("R7 clk_out runs", int'(clk_out), int'(SRC));
        sync_in = 1'b0;
        step(4);

        finish_run();
    end
endmodule